// File: doc/BRIEF.md
# Microstepping Stepper Translator

This block turns a step clock, a direction bit and a three-bit step-mode select into drive information for a two-phase unipolar stepper motor. For each phase it gives two things. The first is the energised polarity: true, complement or off. The second is a four-bit current-ratio code for an external DAC. Code 0 means the phase is off. Codes 1 to 15 stand for 9.8, 19.5, 29, 38.2, 47.1, 55.5, 63.4, 70.7, 77.3, 83.1, 88.2, 92.4, 95.7, 98.1 and 100 percent.

One electrical cycle has 64 positions. Each accepted step moves 16, 8, 4, 2 or 1 positions, set by the mode. Two modes force every energised phase to full current. One mode code puts the sequencer into standby: the drive is off and the position is frozen. Step edges are qualified against minimum high and low times counted in system clocks. Direction and mode are captured only on an accepted step edge. A monitor output marks the positions where both phases sit at the two-phase point.

Top module: `stepper_translator`

## Requirements
- R1: `rst` is asynchronous and active high. While it is high, all polarity outputs and both codes are 0 and the position is home (position 0). After release, with no step, the outputs are `a_pos`=1, `b_pos`=1, both codes 8 and `mon`=1.
- R2: Each accepted rising edge of `step_clk` moves the position exactly once. Without accepted edges the position holds, whether `step_clk` stays high or low.
- R3: At position p (0..63), phase A is driven from index tA=(p+24) mod 64 and phase B from tB=(p+8) mod 64. For index t, take e = t mod 32 when that is 16 or less, and 32 minus it otherwise. The code is e capped at 15. The phase is on in the true sense (`x_pos`) for t in 1..31, on in the complement sense (`x_neg`) for t in 33..63, and off with code 0 at t=0 and t=32. The result: position 0 is A8/B8, and each forward step moves A down and B up.
- R4: `mode` bit 0, bit 1 and bit 2 are the first, second and third select lines. The values 000 and 001 step 16 positions. The values 010 and 011 step 8. The values 100, 101 and 110 step 4, 2 and 1.
- R5: While the last captured mode is 001 or 011, every nonzero code is output as 15. Mode 000 drives code 8 on both phases at the full-step positions.
- R6: `dir`=0 steps towards higher positions and `dir`=1 towards lower positions, wrapping modulo 64.
- R7: Changes on `dir` and `mode` (other than standby) do not affect the outputs until the next accepted step edge.
- R8: If the position is not a multiple of the new step size, a step moves to the nearest multiple in the commanded direction. If it is already a multiple, the step moves one full step size.
- R9: While `mode`=111, taken directly from the input, all polarity outputs and codes are 0 and step edges are ignored. The position and the captured mode are kept for when standby ends.
- R10: `mon` is 1 exactly when the position is a multiple of 16, the two-phase point.
- R11: A rising edge of `step_clk` is accepted only if two conditions hold: the input was low for at least MIN_LOW clocks before it, and the high phase before that low lasted at least MIN_HIGH clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset to home |
| step_clk | input | 1 | Step request, acted on at its rising edge |
| dir | input | 1 | Step direction, 0 ascending |
| mode | input | 3 | Step-size / current / standby select |
| a_pos | output | 1 | Phase A energised, true sense |
| a_neg | output | 1 | Phase A energised, complement sense |
| b_pos | output | 1 | Phase B energised, true sense |
| b_neg | output | 1 | Phase B energised, complement sense |
| a_code | output | 4 | Phase A current-ratio code |
| b_code | output | 4 | Phase B current-ratio code |
| mon | output | 1 | Two-phase position indicator |

## Verification
A wrong position register shows up at once on both codes and on the polarity bits. This is because every position maps to a distinct (A, B) pair. A single step that goes wrong or is missed therefore appears within the next few clocks after the synchronised edge. A bad captured mode appears as full-current codes where 8 or lower were expected. It can also appear as a wrong landing point on the next step. A stale value in the edge-qualification counter shows up as a step that should have been rejected moving the outputs, or as a valid step that leaves them unchanged.

// File: rtl/stepper_translator.sv
module stepper_translator #(
  parameter int MIN_HIGH = 250,
  parameter int MIN_LOW  = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_clk,
  input  logic       dir,
  input  logic [2:0] mode,
  output logic       a_pos,
  output logic       a_neg,
  output logic       b_pos,
  output logic       b_neg,
  output logic [3:0] a_code,
  output logic [3:0] b_code,
  output logic       mon
);
  localparam int CMAX = (MIN_HIGH > MIN_LOW) ? MIN_HIGH : MIN_LOW;
  localparam int CW   = $clog2(CMAX + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] run_cnt;
  logic          hi_ok;
  logic [5:0]    pos;
  logic [2:0]    mode_q;
  logic [5:0]    stride, base, nxt;

  wire lvl    = sync_q[1];
  wire prv    = sync_q[2];
  wire rise   = lvl & ~prv;
  wire sleep  = &mode;
  wire en     = ~rst & ~sleep;
  wire forced = (mode_q == 3'b001) || (mode_q == 3'b011);
  wire step_ok = rise && !sleep && hi_ok && (run_cnt >= CW'(MIN_LOW - 1));

  always_comb begin
    case (mode)
      3'b000, 3'b001: stride = 6'd16;
      3'b010, 3'b011: stride = 6'd8;
      3'b100:         stride = 6'd4;
      3'b101:         stride = 6'd2;
      default:        stride = 6'd1;
    endcase
    base = pos & ~(stride - 6'd1);
    if (!dir)             nxt = base + stride;
    else if (pos == base) nxt = pos - stride;
    else                  nxt = base;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sync_q  <= '0;
      run_cnt <= '0;
      hi_ok   <= 1'b1;
      pos     <= '0;
      mode_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], step_clk};
      if (lvl != prv)                run_cnt <= '0;
      else if (run_cnt != CW'(CMAX)) run_cnt <= run_cnt + 1'b1;
      if (!lvl && prv) hi_ok <= (run_cnt >= CW'(MIN_HIGH - 1));
      if (step_ok) begin
        pos    <= nxt;
        mode_q <= mode;
      end
    end
  end

  function automatic logic [5:0] phase_drive(input logic [5:0] t, input logic frc);
    logic [4:0] d, e;
    logic [3:0] c;
    d = t[4:0];
    e = (d <= 5'd16) ? d : 5'd0 - d;
    c = (e >= 5'd15) ? 4'hF : e[3:0];
    if (frc && c != 4'h0) c = 4'hF;
    return {(c != 4'h0) & ~t[5], (c != 4'h0) & t[5], c};
  endfunction

  wire [5:0] drv_a = phase_drive(pos + 6'd24, forced);
  wire [5:0] drv_b = phase_drive(pos + 6'd8, forced);

  assign {a_pos, a_neg, a_code} = en ? drv_a : 6'd0;
  assign {b_pos, b_neg, b_code} = en ? drv_b : 6'd0;
  assign mon = (pos[3:0] == 4'd0);

  // R1
  always_comb begin
    if (rst) rst_off_chk: assert (!a_pos && !a_neg && !b_pos && !b_neg && a_code == 4'd0 && b_code == 4'd0);
  end

  // R2
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pos) |-> $past(rise));

  // R9
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep && $past(sleep)) |-> ($stable(pos) && $stable(mode_q)));

  // R3
  off_code_chk: assert property (@(posedge clk) disable iff (rst)
    ((a_code == 4'd0) == !(a_pos || a_neg)) && ((b_code == 4'd0) == !(b_pos || b_neg)));

  // R4
  stride_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pos) |-> ((6'(pos - $past(pos)) <= 6'd16) || (6'($past(pos) - pos) <= 6'd16)));

  // R10
  mon_chk: assert property (@(posedge clk) disable iff (rst)
    (mon && !sleep && !forced) |-> (a_code == 4'd8 && b_code == 4'd8));
endmodule

// File: tb/stepper_translator_tb_top.sv
module stepper_translator_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_clk = 1'b0;
  logic dir = 1'b0;
  logic [2:0] mode = 3'b000;
  logic a_pos, a_neg, b_pos, b_neg, mon;
  logic [3:0] a_code, b_code;

  int checks = 0;
  int errors = 0;
  int exp_pos = 0;
  logic [2:0] exp_mode = 3'b000;

  always #4 clk = ~clk;

  stepper_translator #(.MIN_HIGH(4), .MIN_LOW(4)) dut_i (
    .clk(clk), .rst(rst), .step_clk(step_clk), .dir(dir), .mode(mode),
    .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg),
    .a_code(a_code), .b_code(b_code), .mon(mon));

  function automatic int step_size(input logic [2:0] m);
    case (m)
      3'b000, 3'b001: return 16;
      3'b010, 3'b011: return 8;
      3'b100: return 4;
      3'b101: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [12:0] expected();
    int q, k, dec, ris;
    bit dneg, rneg, frc;
    logic ap, an, bp, bn;
    logic [3:0] ac, bc;
    q = exp_pos / 16;
    k = exp_pos % 16;
    if (k < 8) begin dec = 8 - k; ris = 8 + k; end
    else if (k == 8) begin dec = 0; ris = 15; end
    else begin dec = k - 8; ris = (24 - k > 15) ? 15 : 24 - k; end
    frc = (exp_mode == 3'b001) || (exp_mode == 3'b011);
    if (frc && dec != 0) dec = 15;
    if (frc && ris != 0) ris = 15;
    dneg = (q == 2 || q == 3) ^ (k > 8);
    rneg = (q == 1 || q == 2);
    if (q == 0 || q == 2) begin
      ac = 4'(dec); ap = dec != 0 && !dneg; an = dec != 0 && dneg;
      bc = 4'(ris); bp = !rneg;             bn = rneg;
    end else begin
      bc = 4'(dec); bp = dec != 0 && !dneg; bn = dec != 0 && dneg;
      ac = 4'(ris); ap = !rneg;             an = rneg;
    end
    if (rst || mode == 3'b111) begin
      ap = 0; an = 0; bp = 0; bn = 0; ac = 0; bc = 0;
    end
    return {ap, an, bp, bn, ac, bc, (exp_pos % 16) == 0};
  endfunction

  task automatic check_out(input string req);
    logic [12:0] act, exv;
    act = {a_pos, a_neg, b_pos, b_neg, a_code, b_code, mon};
    exv = expected();
    checks++;
    if (act !== exv) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%h expected=%h", req, exp_pos, act, exv);
    end
  endtask

  task automatic model_step(input logic d, input logic [2:0] m);
    int s;
    if (m == 3'b111) return;
    s = step_size(m);
    exp_mode = m;
    if (!d) exp_pos = ((exp_pos / s) * s + s) % 64;
    else if (exp_pos % s == 0) exp_pos = (exp_pos - s + 64) % 64;
    else exp_pos = (exp_pos / s) * s;
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk) step_clk = 1'b1;
    repeat (hi) @(negedge clk);
    step_clk = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic do_step(input logic d, input logic [2:0] m, input string req);
    @(negedge clk);
    dir = d; mode = m;
    pulse(8, 8);
    model_step(d, m);
    check_out(req);
  endtask

  task automatic t_reset();
    @(negedge clk) rst = 1'b1;
    #1 exp_pos = 0; exp_mode = 3'b000;
    check_out("R1 during reset");
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_out("R1 home after reset");
  endtask

  task automatic t_full();
    for (int i = 0; i < 5; i++) do_step(1'b0, 3'b000, "R3 R4 full step");
    for (int i = 0; i < 4; i++) do_step(1'b0, 3'b001, "R5 full step forced");
  endtask

  task automatic t_sweep(input logic [2:0] m, input int n, input string req);
    for (int i = 0; i < n; i++) do_step(1'b0, m, req);
  endtask

  task automatic t_reverse();
    for (int i = 0; i < 20; i++) do_step(1'b1, 3'b110, "R6 reverse sixteenth");
    for (int i = 0; i < 6; i++) do_step(1'b1, 3'b010, "R6 reverse half");
  endtask

  task automatic t_regrid();
    do_step(1'b0, 3'b110, "R8 setup");
    do_step(1'b0, 3'b110, "R8 setup");
    do_step(1'b0, 3'b110, "R8 setup");
    do_step(1'b0, 3'b100, "R8 snap up to quarter grid");
    do_step(1'b0, 3'b110, "R8 setup");
    do_step(1'b1, 3'b101, "R8 snap down to eighth grid");
    do_step(1'b0, 3'b110, "R8 setup");
    do_step(1'b1, 3'b000, "R8 snap down to full grid");
    do_step(1'b1, 3'b000, "R8 full step from grid");
  endtask

  task automatic t_sample();
    do_step(1'b0, 3'b110, "R7 setup");
    @(negedge clk) mode = 3'b001; dir = 1'b1;
    repeat (20) @(negedge clk);
    check_out("R7 mode and dir change without edge");
    pulse(8, 8);
    model_step(1'b1, 3'b001);
    check_out("R7 captured on edge");
  endtask

  task automatic t_hold();
    @(negedge clk) step_clk = 1'b1;
    repeat (60) @(negedge clk);
    model_step(dir, mode);
    check_out("R2 static high holds after one step");
    step_clk = 1'b0;
    repeat (60) @(negedge clk);
    check_out("R2 static low holds");
  endtask

  task automatic t_sleep();
    do_step(1'b0, 3'b101, "R9 setup");
    @(negedge clk) mode = 3'b111;
    #1 check_out("R9 outputs off in standby");
    pulse(8, 8);
    pulse(8, 8);
    check_out("R9 edges ignored in standby");
    @(negedge clk) mode = 3'b101;
    #1 check_out("R9 position kept after standby");
    do_step(1'b0, 3'b101, "R9 stepping resumes");
  endtask

  task automatic t_rate();
    @(negedge clk) dir = 1'b0; mode = 3'b110;
    pulse(8, 2);
    model_step(1'b0, 3'b110);
    pulse(8, 10);
    check_out("R11 short low rejects next edge");
    pulse(1, 10);
    model_step(1'b0, 3'b110);
    check_out("R11 short high pulse itself accepted");
    pulse(8, 10);
    check_out("R11 edge after short high rejected");
    pulse(8, 10);
    model_step(1'b0, 3'b110);
    check_out("R11 normal edge accepted again");
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_full();
    t_sweep(3'b010, 10, "R4 half step");
    t_sweep(3'b011, 8, "R5 half step forced");
    t_sweep(3'b100, 18, "R4 quarter step");
    t_sweep(3'b101, 34, "R4 eighth step");
    t_sweep(3'b110, 66, "R3 R4 sixteenth step full cycle");
    t_reverse();
    t_regrid();
    t_sample();
    t_hold();
    t_sleep();
    t_rate();
    do_step(1'b0, 3'b110, "R10 monitor off grid");
    t_reset();
    finish_run();
  end
endmodule